// File: doc/BRIEF.md
# Three-Channel Fan Drive Controller

This block computes an 8-bit drive level for each of three fans and turns it into either a pulse-width-modulated output or a DC level for an external analog driver. Each channel works in one of three modes. In manual mode the level follows a duty register. In speed mode the level is nudged one step per tachometer update toward a programmed target count, and channel i uses only tachometer i. In temperature mode the level is taken from a piecewise-linear curve through three programmed (temperature, level) trip points, evaluated for each new temperature sample.

Software programs each channel through a byte-wide write port. The PWM carrier has 256 steps, and its step clock comes from a power-of-two prescaler. With a 48 MHz clock this gives 187.5 kHz at the reset setting and reaches the tens-of-hertz range at the largest setting. Temperatures are whole degrees Celsius. A tachometer count is a 12-bit period measurement, so a larger count means a slower fan.

Top module: `fan_ctrl_top`

## Requirements
- R1: After reset every channel is in manual mode with duty 0, PWM selected and prescale exponent 0. Every level_out is 0, every dc_level is 0 and every pwm_out is low.
- R2: Register map per channel: address 0 is control, address 1 is duty, addresses 2 and 3 are the target count (bits 7:0, then bits 11:8 in data bits 3:0), addresses 4 to 6 are trip temperatures T0..T2 and addresses 7 to 9 are trip levels L0..L2. Control bits 1:0 select the mode: 0 manual, 1 speed, 2 temperature, 3 behaves as manual. In manual mode level_out equals the duty register from the second clock edge after the duty write.
- R3: With PWM selected and exponent 0, pwm_out is high for exactly `level` of every 256 consecutive cycles, except that a level of 255 keeps it high for all 256 cycles. A level of 0 keeps it low.
- R4: Control bits 7:4 hold the prescale exponent k, and values above 12 act as 12. Writing a control value whose effective k differs from the stored one restarts the carrier at its first step, after which pwm_out stays high for level × 2^k cycles.
- R5: Control bit 2 selects DC drive. When it is set, dc_level equals level_out and pwm_out stays low. When it is clear, dc_level is 0. No minimum level is enforced in DC mode, so levels below 106 pass through unchanged.
- R6: In speed mode each tach_vld pulse raises the level by 1 if the count is above the target and lowers it by 1 if the count is below it. The level holds when the count equals the target, and it saturates at 0 and 255.
- R7: In speed mode a channel's level changes only on its own tach_vld bit.
- R8: In temperature mode a sample at or below T0 gives L0, and a sample at or above T2 gives L2.
- R9: In temperature mode a sample t strictly between T0 and T2 gives La + (Lb−La)(t−Ta)/(Tb−Ta), with the quotient truncated toward zero. The segment is (T0,T1) when t < T1 and (T1,T2) otherwise.
- R10: In temperature mode level_out changes only on a temp_vld pulse for that channel; a changing temp_c input alone has no effect.
- R11: Writes to a channel index of 3 or to addresses 10 to 15 change no channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel selected by the write |
| wr_addr | input | 4 | Register address within the channel |
| wr_data | input | 8 | Write data |
| temp_vld | input | 3 | New temperature sample, one bit per channel |
| temp_c | input | 24 | Temperature per channel, 8 bits each, degrees Celsius |
| tach_vld | input | 3 | New tachometer count, one bit per channel |
| tach_cnt | input | 36 | Tachometer period count per channel, 12 bits each |
| pwm_out | output | 3 | PWM drive per channel |
| dc_level | output | 24 | DC drive level per channel, 8 bits each |
| level_out | output | 24 | Current drive level per channel, 8 bits each |

## Verification
The carrier restart and the exponent clamp are the hardest cases to reach from the ports, because a full period at the slowest setting lasts about a million cycles. The bench sets a duty of 1 and then writes an exponent of 15, and it measures the single high pulse that follows the restart, which must last exactly 4096 cycles. Saturation in speed mode is reached by preloading the level through manual mode at 0 or 255 and then switching to speed mode. Truncation in the interpolation is exercised with descending trip levels, where the quotient is negative.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;

    localparam int LVL_W   = 8;
    localparam int TEMP_W  = 8;
    localparam int TACH_W  = 12;
    localparam int EXP_W   = 4;
    localparam int MAX_EXP = 12;
    localparam int ADDR_W  = 4;
    localparam int NTRIP   = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_DUTY   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TGT_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_TGT_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_TT0    = 4'd4;
    localparam logic [ADDR_W-1:0] A_TL0    = 4'd7;

    typedef enum logic [1:0] {
        FM_MANUAL = 2'd0,
        FM_SPEED  = 2'd1,
        FM_TEMP   = 2'd2,
        FM_RSVD   = 2'd3
    } fan_mode_e;

    typedef logic [NTRIP-1:0][TEMP_W-1:0] trip_t_t;
    typedef logic [NTRIP-1:0][LVL_W-1:0]  trip_l_t;

    typedef struct packed {
        fan_mode_e            mode;
        logic                 dc_sel;
        logic [EXP_W-1:0]     pexp;
        logic [LVL_W-1:0]     duty;
        logic [TACH_W-1:0]    target;
        trip_t_t              tt;
        trip_l_t              tl;
    } chan_cfg_t;

    function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
        return (int'(e) > MAX_EXP) ? EXP_W'(MAX_EXP) : e;
    endfunction

    function automatic logic [LVL_W-1:0] fan_interp(input trip_t_t tt,
                                                    input trip_l_t tl,
                                                    input logic [TEMP_W-1:0] t);
        int ta, tb, la, lb, r;
        if (t <= tt[0]) return tl[0];
        if (t >= tt[2]) return tl[2];
        if (t < tt[1]) begin
            ta = int'(tt[0]); tb = int'(tt[1]); la = int'(tl[0]); lb = int'(tl[1]);
        end else begin
            ta = int'(tt[1]); tb = int'(tt[2]); la = int'(tl[1]); lb = int'(tl[2]);
        end
        r = la + ((lb - la) * (int'(t) - ta)) / (tb - ta);
        return r[LVL_W-1:0];
    endfunction

endpackage

// File: rtl/fan_regs.sv
module fan_regs
    import fan_ctrl_pkg::*;
#(
    parameter int CH   = 0,
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output chan_cfg_t         cfg,
    output logic              restart
);

    logic             hit;
    logic [EXP_W-1:0] new_exp;

    assign hit     = wr_en && (wr_ch == CH_W'(CH));
    assign new_exp = clamp_exp(wr_data[7:4]);
    assign restart = hit && (wr_addr == A_CTRL) && (new_exp != cfg.pexp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg.mode   <= fan_mode_e'(wr_data[1:0]);
                    cfg.dc_sel <= wr_data[2];
                    cfg.pexp   <= new_exp;
                end
                A_DUTY:   cfg.duty          <= wr_data;
                A_TGT_LO: cfg.target[7:0]   <= wr_data;
                A_TGT_HI: cfg.target[11:8]  <= wr_data[3:0];
                4'd4:     cfg.tt[0]         <= wr_data;
                4'd5:     cfg.tt[1]         <= wr_data;
                4'd6:     cfg.tt[2]         <= wr_data;
                A_TL0:    cfg.tl[0]         <= wr_data;
                4'd8:     cfg.tl[1]         <= wr_data;
                4'd9:     cfg.tl[2]         <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fan_level.sv
module fan_level
    import fan_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fan_mode_e         mode,
    input  logic [LVL_W-1:0]  duty,
    input  logic [TACH_W-1:0] target,
    input  trip_t_t           tt,
    input  trip_l_t           tl,
    input  logic              tach_vld,
    input  logic [TACH_W-1:0] tach_cnt,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_c,
    output logic [LVL_W-1:0]  level
);

    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            case (mode)
                FM_SPEED: begin
                    if (tach_vld) begin
                        if (tach_cnt > target && level != LVL_MAX)
                            level <= level + 1'b1;
                        else if (tach_cnt < target && level != '0)
                            level <= level - 1'b1;
                    end
                end
                FM_TEMP: begin
                    if (temp_vld) level <= fan_interp(tt, tl, temp_c);
                end
                default: level <= duty;
            endcase
        end
    end

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_MANUAL) |=> (level == $past(duty))); // R2

    AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_SPEED && !tach_vld) |=> $stable(level)); // R7

    AST_SPEED_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_SPEED && tach_vld && tach_cnt > target && level == LVL_MAX)
        |=> (level == LVL_MAX)); // R6

    AST_SPEED_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_SPEED && tach_vld && tach_cnt < target && level == '0)
        |=> (level == '0)); // R6

    AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == FM_TEMP && !temp_vld) |=> $stable(level)); // R10

endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
    import fan_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] pexp,
    input  logic             restart,
    input  logic             dc_sel,
    input  logic [LVL_W-1:0] level,
    output logic             pwm,
    output logic [LVL_W-1:0] dc_level
);

    localparam int PRE_W = MAX_EXP;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic [LVL_W-1:0] step;
    logic             tick;

    assign mask = PRE_W'(({{PRE_W{1'b0}}, 1'b1} << pexp) - 1'b1);
    assign tick = (pre >= mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre  <= '0;
            step <= '0;
        end else if (tick) begin
            pre  <= '0;
            step <= step + 1'b1;
        end else begin
            pre  <= pre + 1'b1;
        end
    end

    assign pwm      = !dc_sel && ((level == '1) || (step < level));
    assign dc_level = dc_sel ? level : '0;

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre == '0 && step == '0)); // R4

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> (step == $past(step) + 1'b1)); // R3

endmodule

// File: rtl/fan_ctrl_top.sv
module fan_ctrl_top
    import fan_ctrl_pkg::*;
#(
    parameter  int NCH  = 3,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [NCH-1:0]          temp_vld,
    input  logic [NCH*TEMP_W-1:0]   temp_c,
    input  logic [NCH-1:0]          tach_vld,
    input  logic [NCH*TACH_W-1:0]   tach_cnt,
    output logic [NCH-1:0]          pwm_out,
    output logic [NCH*LVL_W-1:0]    dc_level,
    output logic [NCH*LVL_W-1:0]    level_out
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_cfg_t        cfg;
        logic             restart;
        logic [LVL_W-1:0] level;

        fan_regs #(.CH(g), .CH_W(CH_W)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_ch   (wr_ch),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .cfg     (cfg),
            .restart (restart)
        );

        fan_level u_level (
            .clk      (clk),
            .rst      (rst),
            .mode     (cfg.mode),
            .duty     (cfg.duty),
            .target   (cfg.target),
            .tt       (cfg.tt),
            .tl       (cfg.tl),
            .tach_vld (tach_vld[g]),
            .tach_cnt (tach_cnt[g*TACH_W +: TACH_W]),
            .temp_vld (temp_vld[g]),
            .temp_c   (temp_c[g*TEMP_W +: TEMP_W]),
            .level    (level)
        );

        fan_pwm u_pwm (
            .clk      (clk),
            .rst      (rst),
            .pexp     (cfg.pexp),
            .restart  (restart),
            .dc_sel   (cfg.dc_sel),
            .level    (level),
            .pwm      (pwm_out[g]),
            .dc_level (dc_level[g*LVL_W +: LVL_W])
        );

        assign level_out[g*LVL_W +: LVL_W] = level;

        AST_DC_PWM_QUIET: assert property (@(posedge clk) disable iff (rst)
            (cfg.dc_sel && $past(cfg.dc_sel)) |-> !pwm_out[g]); // R5
    end

endmodule

// File: tb/fan_ctrl_top_bench.sv
module fan_ctrl_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  temp_vld = '0;
    logic [23:0] temp_c = '0;
    logic [2:0]  tach_vld = '0;
    logic [35:0] tach_cnt = '0;
    logic [2:0]  pwm_out;
    logic [23:0] dc_level;
    logic [23:0] level_out;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_ctrl_top #(.NCH(NCH)) u_fan_ctrl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
        .wr_data(wr_data), .temp_vld(temp_vld), .temp_c(temp_c),
        .tach_vld(tach_vld), .tach_cnt(tach_cnt), .pwm_out(pwm_out),
        .dc_level(dc_level), .level_out(level_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl(input int ch);
        return int'(level_out[ch*8 +: 8]);
    endfunction

    function automatic int interp_ref(input int t0, input int t1, input int t2,
                                      input int l0, input int l1, input int l2,
                                      input int t);
        if (t <= t0) return l0;
        if (t >= t2) return l2;
        if (t < t1) return l0 + ((l1 - l0) * (t - t0)) / (t1 - t0);
        return l1 + ((l2 - l1) * (t - t1)) / (t2 - t1);
    endfunction

    task automatic wr(input int ch, input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctrl(input int ch, input int mode, input int dc, input int k);
        wr(ch, 0, (k << 4) | (dc << 2) | mode);
    endtask

    task automatic tach(input int ch, input int cnt);
        @(negedge clk);
        tach_cnt[ch*12 +: 12] = 12'(cnt); tach_vld[ch] = 1'b1;
        @(negedge clk);
        tach_vld[ch] = 1'b0;
    endtask

    task automatic temp(input int ch, input int t);
        @(negedge clk);
        temp_c[ch*8 +: 8] = 8'(t); temp_vld[ch] = 1'b1;
        @(negedge clk);
        temp_vld[ch] = 1'b0;
    endtask

    task automatic count_window(input int ch, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) highs++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_len(input int ch, input int maxc, output int n);
        n = 0;
        while (pwm_out[ch] && n < maxc) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, model, tgt, cnt;
        int tt[3], tl[3];
        int t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            check("R1 level", lvl(c), 0);
            check("R1 dc", int'(dc_level[c*8 +: 8]), 0);
            check("R1 pwm", int'(pwm_out[c]), 0);
        end

        // R2 manual follow
        wr(0, 1, 90); @(negedge clk);
        check("R2 manual duty ch0", lvl(0), 90);
        wr(2, 1, 77); @(negedge clk);
        check("R2 manual duty ch2", lvl(2), 77);
        ctrl(1, 3, 0, 0); wr(1, 1, 33); @(negedge clk);
        check("R2 mode 3 as manual", lvl(1), 33);

        // R3 duty over one 256-cycle period, k=0
        for (int i = 0; i < 6; i++) begin
            int d;
            d = (i == 0) ? 0 : (i == 1) ? 255 : (i == 2) ? 1 : int'($urandom_range(2, 254));
            wr(0, 1, d); @(negedge clk);
            count_window(0, 256, h);
            check("R3 pwm highs", h, (d == 255) ? 256 : d);
        end

        // R4 restart and prescale
        wr(0, 1, 3); @(negedge clk);
        ctrl(0, 0, 0, 1);
        pulse_len(0, 40000, h);
        check("R4 pulse k=1", h, 6);
        wr(0, 1, 1); @(negedge clk);
        ctrl(0, 0, 0, 15);
        pulse_len(0, 40000, h);
        check("R4 pulse clamp to 12", h, 4096);
        ctrl(0, 0, 0, 0);
        pulse_len(0, 40000, h);
        check("R4 pulse k=0", h, 1);

        // R5 DC path with level below 106
        wr(0, 1, 50); ctrl(0, 0, 1, 0); @(negedge clk);
        check("R5 dc level", int'(dc_level[7:0]), 50);
        count_window(0, 256, h);
        check("R5 pwm quiet", h, 0);
        ctrl(0, 0, 0, 0); @(negedge clk);
        check("R5 dc zero in pwm", int'(dc_level[7:0]), 0);

        // R6 saturation
        wr(0, 1, 255); @(negedge clk);
        wr(0, 2, 100); wr(0, 3, 0); ctrl(0, 1, 0, 0);
        tach(0, 500);
        check("R6 clamp high", lvl(0), 255);
        ctrl(0, 0, 0, 0); wr(0, 1, 0); @(negedge clk);
        ctrl(0, 1, 0, 0);
        tach(0, 50);
        check("R6 clamp low", lvl(0), 0);

        // R6 random walk ch0, R7 ch2 held in speed with no tach pulses
        ctrl(0, 0, 0, 0); wr(0, 1, 128); @(negedge clk);
        tgt = int'($urandom_range(200, 3800));
        wr(0, 2, tgt & 255); wr(0, 3, tgt >> 8);
        ctrl(0, 1, 0, 0);
        ctrl(2, 1, 0, 0);
        model = 128;
        for (int i = 0; i < 40; i++) begin
            cnt = (i % 5 == 0) ? tgt : int'($urandom_range(0, 4095));
            tach_cnt[35:24] = 12'($urandom_range(0, 4095));
            tach(0, cnt);
            if (cnt > tgt && model < 255) model++;
            else if (cnt < tgt && model > 0) model--;
            check("R6 speed step", lvl(0), model);
        end
        check("R7 other channel unaffected", lvl(2), 77);

        // R8/R9 directed temperature curve on ch1
        ctrl(1, 2, 0, 0);
        wr(1, 4, 30); wr(1, 5, 50); wr(1, 6, 70);
        wr(1, 7, 40); wr(1, 8, 120); wr(1, 9, 250);
        temp(1, 20); check("R8 below T0", lvl(1), 40);
        temp(1, 30); check("R8 at T0", lvl(1), 40);
        temp(1, 90); check("R8 above T2", lvl(1), 250);
        temp(1, 70); check("R8 at T2", lvl(1), 250);
        temp(1, 40); check("R9 seg0", lvl(1), 80);
        temp(1, 50); check("R9 at T1", lvl(1), 120);
        temp(1, 55); check("R9 seg1 trunc", lvl(1), 152);
        wr(1, 7, 200); wr(1, 8, 100); wr(1, 9, 50);
        temp(1, 45); check("R9 descending", lvl(1), 125);
        temp(1, 61); check("R9 negative trunc", lvl(1), 73);

        // R10 temp_c change without strobe
        @(negedge clk); temp_c[15:8] = 8'd20;
        repeat (3) @(negedge clk);
        check("R10 no strobe no change", lvl(1), 73);

        // R9 random curves
        for (int j = 0; j < 4; j++) begin
            for (int k = 0; k < 3; k++) tt[k] = int'($urandom_range(0, 255));
            for (int k = 0; k < 3; k++) tl[k] = int'($urandom_range(0, 255));
            if (tt[0] > tt[1]) begin t = tt[0]; tt[0] = tt[1]; tt[1] = t; end
            if (tt[1] > tt[2]) begin t = tt[1]; tt[1] = tt[2]; tt[2] = t; end
            if (tt[0] > tt[1]) begin t = tt[0]; tt[0] = tt[1]; tt[1] = t; end
            for (int k = 0; k < 3; k++) begin
                wr(1, 4 + k, tt[k]); wr(1, 7 + k, tl[k]);
            end
            for (int i = 0; i < 10; i++) begin
                t = int'($urandom_range(0, 255));
                temp(1, t);
                check("R9 random interp", lvl(1),
                      interp_ref(tt[0], tt[1], tt[2], tl[0], tl[1], tl[2], t));
            end
        end

        // R11 ignored writes
        ctrl(0, 0, 0, 0); wr(0, 1, 11); wr(1, 1, 22); ctrl(1, 0, 0, 0);
        ctrl(2, 0, 0, 0); wr(2, 1, 33);
        wr(3, 1, 200); wr(3, 0, 8'h01);
        wr(0, 12, 99); wr(1, 15, 99); wr(2, 10, 1);
        @(negedge clk);
        check("R11 ch0", lvl(0), 11);
        check("R11 ch1", lvl(1), 22);
        check("R11 ch2", lvl(2), 33);
        count_window(2, 256, h);
        check("R11 ch2 pwm", h, 33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule